// File: doc/BRIEF.md
# Serial Peripheral Master with Threshold FIFOs

This core drives a four-wire serial bus as the clock-generating side. Software-side logic pushes words into a transmit queue and pops received words from a receive queue. Every word that leaves the transmit queue is shifted out most significant bit first. The bits sampled from the input line during that transfer form exactly one word in the receive queue. The two queues each have a storage budget of sixteen bytes, so the number of words they hold depends on the selected word width of 8, 16 or 32 bits.

Two level-sensitive interrupt lines report queue occupancy, and each has a four-way select of the condition it tracks. Clock polarity, the edge on which output data changes and the input sample point are set by separate controls. The bit rate comes from a 9-bit divisor. An optional hardware chip-select stays low for as long as the transmit side has work. Clearing the enable stops shifting at once and empties both queues.

Top module: `spi_fifo_master`

## Requirements
- R1: Word-size code 0 selects 8-bit words, 1 selects 16 bits, 2 selects 32 bits, and the reserved code 3 behaves as 8 bits. Pushed data is cut to the word width, and a received word has zeros above that width.
- R2: Queue depth in words is 16, 8 or 4 for 8, 16 and 32-bit words. A push into a full transmit queue is dropped and the queue level stays at the depth.
- R3: While a transfer runs, one serial clock period lasts 2×(divisor+1) input clock cycles.
- R4: The serial clock rests at 0 when the polarity input is 0 and at 1 when it is 1, both before and after transfers.
- R5: Output data goes out most significant bit first. With the edge select at 1, the output is stable at each idle-to-active clock edge. With the edge select at 0, it is stable at each active-to-idle edge.
- R6: With loopback wiring, the received word equals the sent word under every combination of polarity, edge select and sample select (0 samples mid-bit, 1 samples at the end of the bit).
- R7: Receive interrupt select: 0 = queue empty; 1 = at least one word; 2 = at least half the depth; 3 = exactly full.
- R8: Transmit interrupt select: 0 = queue empty and no transfer in progress; 1 = queue empty; 2 = level at most half the depth; 3 = at least one free slot.
- R9: A word that completes while the receive queue is full is discarded and sets a sticky overflow flag. The flag is cleared only by the clear input or by reset.
- R10: Both queue levels are reported as 5-bit word counts, together with a receive-empty flag. A pop from an empty receive queue reads zero and changes no level.
- R11: With hardware select enabled, the active-low select is 0 while the transmit queue holds a word or a transfer is in progress, and 1 otherwise. With hardware select disabled, it stays 1.
- R12: When enable is low, shifting stops, the serial clock returns to its rest level within one cycle and both queue levels read zero.
- R13: After reset both levels are zero, receive-empty is 1, the overflow flag is 0, the select is 1 and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Core enable; low flushes both queues |
| wsize | input | 2 | Word-size code (0:8, 1:16, 2:32, 3:8 bits) |
| cpol | input | 1 | Serial clock rest level |
| cke | input | 1 | 1: output changes on active-to-idle edge |
| smp | input | 1 | 1: sample input at end of bit time |
| brg | input | 9 | Bit-rate divisor |
| tx_isel | input | 2 | Transmit interrupt condition select |
| rx_isel | input | 2 | Receive interrupt condition select |
| ss_hw_en | input | 1 | Enable hardware chip-select |
| tx_push | input | 1 | Push tx_data into the transmit queue |
| tx_data | input | 32 | Word to push |
| rx_pop | input | 1 | Pop the head of the receive queue |
| rx_data | output | 32 | Head of the receive queue, zero when empty |
| ovf_clr | input | 1 | Clear the overflow flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low chip-select |
| tx_level | output | 5 | Transmit queue word count |
| rx_level | output | 5 | Receive queue word count |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |

## Verification
A pushed word enters the transmit level at the next edge. The engine removes it one edge later. The received word appears in the receive level on the edge of the last half-bit tick, which is 1 + 2N×(divisor+1) cycles after the load. The bench therefore waits on the receive level instead of a fixed count, except for overflow, where it waits well beyond one word time. The interrupt lines, select output, read data and serial clock are decoded from registered state. They are sampled one time step after a control change, in the cycle the change is made, and queue effects are sampled after the following edge. Clock period and bit order are measured by a monitor at the falling core-clock edge, away from the edge that moves the serial clock.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        WS_8    = 2'd0,
        WS_16   = 2'd1,
        WS_32   = 2'd2,
        WS_RSVD = 2'd3
    } wsize_e;

    typedef enum logic [1:0] {
        RXT_EMPTY = 2'd0,
        RXT_ANY   = 2'd1,
        RXT_HALF  = 2'd2,
        RXT_FULL  = 2'd3
    } rx_thr_e;

    typedef enum logic [1:0] {
        TXT_DRAINED = 2'd0,
        TXT_EMPTY   = 2'd1,
        TXT_HALF    = 2'd2,
        TXT_ROOM    = 2'd3
    } tx_thr_e;

    // bytes per word for a size code; the reserved code falls back to one byte
    function automatic int unsigned word_bytes(logic [1:0] code);
        case (wsize_e'(code))
            WS_16:   return 2;
            WS_32:   return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DW      = 32,
    parameter int ENTRIES = 16,
    parameter int CW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] depth,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic [DW-1:0] mem_q [ENTRIES];
    logic wr_ok, rd_ok;

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PW'(ENTRIES - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (fifo_q.cnt >= depth);
    assign wr_ok = wr && !full && !flush;
    assign rd_ok = rd && (fifo_q.cnt != '0) && !flush;

    always_comb begin
        fifo_d = fifo_q;
        if (flush) begin
            fifo_d = '0;
        end else begin
            if (wr_ok) fifo_d.wp = ptr_next(fifo_q.wp);
            if (rd_ok) fifo_d.rp = ptr_next(fifo_q.rp);
            fifo_d.cnt = fifo_q.cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[fifo_q.wp] <= wdata;
    end

    assign rdata = mem_q[fifo_q.rp];
    assign count = fifo_q.cnt;

endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
    parameter int DW    = 32,
    parameter int BRG_W = 9,
    parameter int NBW   = 6,
    parameter int HW    = NBW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cke,
    input  logic             smp,
    input  logic             miso,
    input  logic [BRG_W-1:0] brg,
    input  logic [NBW-1:0]   nbits,
    input  logic             tx_avail,
    input  logic [DW-1:0]    tx_word,
    output logic             tx_pop,
    output logic             done,
    output logic [DW-1:0]    rx_word,
    output logic             busy,
    output logic             act,
    output logic             mosi
);
    typedef struct packed {
        logic             busy;
        logic [BRG_W-1:0] div;
        logic [HW-1:0]    half;
        logic             act;
        logic [DW-1:0]    sreg;
        logic [DW-1:0]    rsh;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [NBW-1:0] lshift;
    logic [HW-1:0]  last_half;
    logic           is_last;
    logic           do_sample;

    assign lshift    = NBW'(DW) - nbits;
    assign last_half = {nbits, 1'b0} - HW'(1);
    assign is_last   = (eng_q.half == last_half);
    // even half-index ends mid-bit, odd half-index ends the bit
    assign do_sample = smp ? eng_q.half[0] : ~eng_q.half[0];

    always_comb begin
        eng_d  = eng_q;
        tx_pop = 1'b0;
        done   = 1'b0;
        if (!en) begin
            eng_d.busy = 1'b0;
            eng_d.act  = 1'b0;
            eng_d.div  = '0;
            eng_d.half = '0;
        end else if (!eng_q.busy) begin
            if (tx_avail) begin
                tx_pop     = 1'b1;
                eng_d.busy = 1'b1;
                eng_d.div  = '0;
                eng_d.half = '0;
                eng_d.act  = ~cke;
                eng_d.sreg = tx_word << lshift;
                eng_d.rsh  = '0;
            end
        end else if (eng_q.div == brg) begin
            eng_d.div = '0;
            if (do_sample) eng_d.rsh = {eng_q.rsh[DW-2:0], miso};
            if (eng_q.half[0] && !is_last) eng_d.sreg = eng_q.sreg << 1;
            if (cke || !is_last) eng_d.act = ~eng_q.act;
            if (is_last) begin
                eng_d.busy = 1'b0;
                done       = 1'b1;
            end
            eng_d.half = eng_q.half + 1'b1;
        end else begin
            eng_d.div = eng_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign rx_word = eng_d.rsh;
    assign busy    = eng_q.busy;
    assign act     = eng_q.act;
    assign mosi    = eng_q.sreg[DW-1];

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
    parameter int FIFO_BYTES = 16,
    parameter int DW         = 32,
    parameter int BRG_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       wsize,
    input  logic             cpol,
    input  logic             cke,
    input  logic             smp,
    input  logic [BRG_W-1:0] brg,
    input  logic [1:0]       tx_isel,
    input  logic [1:0]       rx_isel,
    input  logic             ss_hw_en,
    input  logic             tx_push,
    input  logic [DW-1:0]    tx_data,
    input  logic             rx_pop,
    output logic [DW-1:0]    rx_data,
    input  logic             ovf_clr,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             ss_n,
    output logic [$clog2(FIFO_BYTES+1)-1:0] tx_level,
    output logic [$clog2(FIFO_BYTES+1)-1:0] rx_level,
    output logic             rx_empty,
    output logic             rx_ovf,
    output logic             tx_irq,
    output logic             rx_irq
);
    import spim_pkg::*;

    localparam int CW  = $clog2(FIFO_BYTES + 1);
    localparam int NBW = $clog2(DW + 1);
    localparam int HW  = NBW + 1;

    typedef struct packed {
        logic ovf;
    } top_t;

    top_t top_d, top_q;

    logic [CW-1:0]  depth, half_depth;
    logic [NBW-1:0] nbits;
    logic [DW-1:0]  word_mask;
    logic [DW-1:0]  tx_head, rx_head, rx_word;
    logic [CW-1:0]  tx_cnt, rx_cnt;
    logic           tx_full, rx_full;
    logic           eng_pop, eng_done, eng_busy, eng_act;

    always_comb begin
        depth      = CW'(FIFO_BYTES / word_bytes(wsize));
        nbits      = NBW'(8 * word_bytes(wsize));
        half_depth = depth >> 1;
        word_mask  = (nbits >= NBW'(DW)) ? '1 : ((DW'(1) << nbits) - DW'(1));
    end

    spim_fifo #(.DW(DW), .ENTRIES(FIFO_BYTES), .CW(CW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (~en),
        .depth (depth),
        .wr    (tx_push),
        .wdata (tx_data & word_mask),
        .rd    (eng_pop),
        .rdata (tx_head),
        .count (tx_cnt),
        .full  (tx_full)
    );

    spim_fifo #(.DW(DW), .ENTRIES(FIFO_BYTES), .CW(CW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (~en),
        .depth (depth),
        .wr    (eng_done),
        .wdata (rx_word & word_mask),
        .rd    (rx_pop),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full)
    );

    spim_engine #(.DW(DW), .BRG_W(BRG_W), .NBW(NBW), .HW(HW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cke      (cke),
        .smp      (smp),
        .miso     (miso),
        .brg      (brg),
        .nbits    (nbits),
        .tx_avail (tx_cnt != '0),
        .tx_word  (tx_head),
        .tx_pop   (eng_pop),
        .done     (eng_done),
        .rx_word  (rx_word),
        .busy     (eng_busy),
        .act      (eng_act),
        .mosi     (mosi)
    );

    // overflow flag: a new overflow wins over a clear in the same cycle
    always_comb begin
        top_d = top_q;
        if (ovf_clr)             top_d.ovf = 1'b0;
        if (eng_done && rx_full) top_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        case (tx_thr_e'(tx_isel))
            TXT_DRAINED: tx_irq = (tx_cnt == '0) && !eng_busy;
            TXT_EMPTY:   tx_irq = (tx_cnt == '0);
            TXT_HALF:    tx_irq = (tx_cnt <= half_depth);
            default:     tx_irq = (tx_cnt < depth);
        endcase
        case (rx_thr_e'(rx_isel))
            RXT_EMPTY: rx_irq = (rx_cnt == '0);
            RXT_ANY:   rx_irq = (rx_cnt != '0);
            RXT_HALF:  rx_irq = (rx_cnt >= half_depth);
            default:   rx_irq = (rx_cnt >= depth);
        endcase
    end

    assign tx_level = tx_cnt;
    assign rx_level = rx_cnt;
    assign rx_empty = (rx_cnt == '0);
    assign rx_data  = rx_empty ? '0 : rx_head;
    assign rx_ovf   = top_q.ovf;
    assign sck      = cpol ^ eng_act;
    assign ss_n     = ~(ss_hw_en && en && ((tx_cnt != '0) || eng_busy));

endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int FIFO_BYTES = 16,
    parameter int CW         = $clog2(FIFO_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [1:0]    wsize,
    input logic          cpol,
    input logic          ss_hw_en,
    input logic          ovf_clr,
    input logic          sck,
    input logic          ss_n,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_level,
    input logic          rx_ovf
);
    function automatic logic [CW-1:0] dep(logic [1:0] code);
        case (code)
            2'd1:    return CW'(FIFO_BYTES / 2);
            2'd2:    return CW'(FIFO_BYTES / 4);
            default: return CW'(FIFO_BYTES);
        endcase
    endfunction

    // R12
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sck == cpol && tx_level == '0 && rx_level == '0));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !ovf_clr) |=> rx_ovf);

    // R9
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> ($past(rx_level) == dep($past(wsize))));

    // R2
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $stable(wsize) && tx_level <= dep(wsize)) |=> (tx_level <= dep(wsize)));

    // R11
    ss_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_hw_en && en && tx_level != '0) |-> !ss_n);

    // R11
    ss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_hw_en |-> ss_n);

endmodule

bind spi_fifo_master spim_checker u_chk (.*);

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  wsize = 2'd0;
    logic        cpol = 1'b0, cke = 1'b1, smp = 1'b0;
    logic [8:0]  brg = 9'd0;
    logic [1:0]  tx_isel = 2'd0, rx_isel = 2'd0;
    logic        ss_hw_en = 1'b0;
    logic        tx_push = 1'b0;
    logic [31:0] tx_data = '0;
    logic        rx_pop = 1'b0;
    logic [31:0] rx_data;
    logic        ovf_clr = 1'b0;
    logic        sck, mosi, miso, ss_n;
    logic [4:0]  tx_level, rx_level;
    logic        rx_empty, rx_ovf, tx_irq, rx_irq;
    logic        loop_on = 1'b1, miso_lvl = 1'b0;

    int nchk = 0, nfail = 0;
    int cyc = 0;

    assign miso = loop_on ? mosi : miso_lvl;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_fifo_master dut (.*);

    // bus monitor: bit order and clock period, sampled away from the moving edge
    logic        sck_prev = 1'b0;
    logic [31:0] mon_sh = '0;
    int          rise_cyc = 0, sck_period = 0;
    always @(negedge clk) begin
        if (sck !== sck_prev) begin
            if (((sck != cpol) && cke) || ((sck == cpol) && !cke))
                mon_sh <= {mon_sh[30:0], mosi};
            if (sck) begin
                sck_period <= cyc - rise_cyc;
                rise_cyc   <= cyc;
            end
        end
        sck_prev <= sck;
    end

    function automatic int wbits(logic [1:0] w);
        return (w == 2'd1) ? 16 : (w == 2'd2) ? 32 : 8;
    endfunction
    function automatic int wdepth(logic [1:0] w);
        return 16 / (wbits(w) / 8);
    endfunction
    function automatic logic [31:0] wmask(logic [1:0] w);
        return (wbits(w) == 32) ? 32'hFFFF_FFFF : ((32'd1 << wbits(w)) - 32'd1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic cfg(input logic [1:0] w, input logic p, input logic e,
                       input logic s, input logic [8:0] b);
        en = 1'b0;
        step(1);
        wsize = w; cpol = p; cke = e; smp = s; brg = b;
        en = 1'b1;
        step(1);
    endtask

    task automatic push(input logic [31:0] w);
        tx_data = w; tx_push = 1'b1;
        step(1);
        tx_push = 1'b0;
    endtask

    task automatic pop(output logic [31:0] w);
        w = rx_data;
        rx_pop = 1'b1;
        step(1);
        rx_pop = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        for (int i = 0; i < 100000 && rx_level < 5'(n); i++) step(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [31:0] words [16];
        void'($urandom(32'h5A17));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R13 reset state
        chk("R13 tx_level", 32'(tx_level), 0);
        chk("R13 rx_level", 32'(rx_level), 0);
        chk("R13 rx_empty", 32'(rx_empty), 1);
        chk("R13 rx_ovf", 32'(rx_ovf), 0);
        chk("R13 ss_n", 32'(ss_n), 1);
        chk("R13 rx_data", rx_data, 0);
        chk("R13 R4 sck idle", 32'(sck), 0);

        // R5 + R3: bit order with edge select 1, clock period with divisor 2
        cfg(2'd1, 1'b0, 1'b1, 1'b0, 9'd2);
        push(32'h0000A5C3);
        wait_rx(1);
        chk("R5 msb first cke1", {16'h0, mon_sh[15:0]}, 32'hA5C3);
        chk("R3 period brg2", 32'(sck_period), 6);
        pop(got);
        chk("R6 loopback cke1 smp0", got, 32'hA5C3);
        // R5 edge select 0, sample at end, divisor 4
        cfg(2'd1, 1'b0, 1'b0, 1'b1, 9'd4);
        push(32'h00003C5A);
        wait_rx(1);
        chk("R5 msb first cke0", {16'h0, mon_sh[15:0]}, 32'h3C5A);
        chk("R3 period brg4", 32'(sck_period), 10);
        pop(got);
        chk("R6 loopback cke0 smp1", got, 32'h3C5A);

        // R4 high rest level
        cfg(2'd0, 1'b1, 1'b1, 1'b0, 9'd1);
        chk("R4 sck idle high", 32'(sck), 1);
        push(32'h0000_00B7);
        wait_rx(1);
        chk("R4 sck idle high after", 32'(sck), 1);
        pop(got);
        chk("R6 loopback cpol1", got, 32'hB7);

        // R1 reserved code and masking, constant input line
        cfg(2'd3, 1'b0, 1'b1, 1'b0, 9'd0);
        push(32'h1234_5678);
        wait_rx(1);
        pop(got);
        chk("R1 reserved code 8-bit", got, 32'h78);
        loop_on = 1'b0; miso_lvl = 1'b1;
        cfg(2'd1, 1'b0, 1'b1, 1'b1, 9'd0);
        push(32'h0);
        wait_rx(1);
        pop(got);
        chk("R1 16-bit all ones", got, 32'h0000FFFF);
        loop_on = 1'b1;

        // R2 depth saturation per size code
        for (int w = 0; w < 4; w++) begin
            cfg(2'(w), 1'b0, 1'b1, 1'b0, 9'd100);
            for (int k = 0; k < wdepth(2'(w)) + 3; k++) push(32'hC0DE_0000 + 32'(k));
            chk($sformatf("R2 full level ws%0d", w), 32'(tx_level), 32'(wdepth(2'(w))));
            tx_isel = 2'd3; #1;
            chk("R8 sel3 full", 32'(tx_irq), 0);
            en = 1'b0;
            step(1);
            chk("R12 flush tx", 32'(tx_level), 0);
            chk("R12 sck rest", 32'(sck), 0);
        end

        // R8 transmit thresholds, 8-bit words, depth 16
        cfg(2'd0, 1'b0, 1'b1, 1'b0, 9'd100);
        tx_isel = 2'd0; #1;
        chk("R8 sel0 idle", 32'(tx_irq), 1);
        push(32'h11);
        step(1);
        chk("R8 sel0 busy", 32'(tx_irq), 0);
        tx_isel = 2'd1; #1;
        chk("R8 sel1 busy empty", 32'(tx_irq), 1);
        for (int k = 0; k < 8; k++) push(32'h20 + 32'(k));
        chk("R10 tx level 8", 32'(tx_level), 8);
        chk("R8 sel1 nonempty", 32'(tx_irq), 0);
        tx_isel = 2'd2; #1;
        chk("R8 sel2 at half", 32'(tx_irq), 1);
        push(32'h30);
        chk("R8 sel2 above half", 32'(tx_irq), 0);
        tx_isel = 2'd3; #1;
        chk("R8 sel3 room", 32'(tx_irq), 1);
        // R12 disable mid-transfer
        en = 1'b0;
        step(1);
        chk("R12 sck rest mid", 32'(sck), 0);
        chk("R12 tx flushed", 32'(tx_level), 0);
        en = 1'b1;

        // R7 + R9 receive thresholds and overflow, 32-bit words, depth 4
        cfg(2'd2, 1'b0, 1'b1, 1'b0, 9'd0);
        rx_isel = 2'd0; #1;
        chk("R7 sel0 empty", 32'(rx_irq), 1);
        words[0] = 32'hDEAD_BEEF;
        push(words[0]);
        wait_rx(1);
        chk("R7 sel0 one", 32'(rx_irq), 0);
        rx_isel = 2'd1; #1;
        chk("R7 sel1 one", 32'(rx_irq), 1);
        rx_isel = 2'd2; #1;
        chk("R7 sel2 one", 32'(rx_irq), 0);
        push(32'h0102_0304);
        wait_rx(2);
        chk("R7 sel2 half", 32'(rx_irq), 1);
        rx_isel = 2'd3; #1;
        chk("R7 sel3 half", 32'(rx_irq), 0);
        push(32'h5); push(32'h6);
        wait_rx(4);
        chk("R7 sel3 full", 32'(rx_irq), 1);
        push(32'h7777_7777);
        step(120);
        chk("R9 level held", 32'(rx_level), 4);
        chk("R9 ovf set", 32'(rx_ovf), 1);
        pop(got);
        chk("R9 head kept", got, words[0]);
        step(2);
        chk("R9 ovf sticky", 32'(rx_ovf), 1);
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        chk("R9 ovf cleared", 32'(rx_ovf), 0);
        for (int k = 0; k < 3; k++) pop(got);
        chk("R9 dropped word absent", got, 32'h6);
        // R10 pop when empty
        chk("R10 empty flag", 32'(rx_empty), 1);
        pop(got);
        chk("R10 empty pop data", got, 0);
        chk("R10 empty pop level", 32'(rx_level), 0);

        // R11 hardware select
        ss_hw_en = 1'b1;
        cfg(2'd0, 1'b0, 1'b1, 1'b0, 9'd20);
        chk("R11 idle high", 32'(ss_n), 1);
        push(32'h3); push(32'h4);
        chk("R11 low while queued", 32'(ss_n), 0);
        step(3);
        chk("R11 low while shifting", 32'(ss_n), 0);
        wait_rx(2);
        chk("R11 high after drain", 32'(ss_n), 1);
        ss_hw_en = 1'b0;
        push(32'h9);
        step(2);
        chk("R11 disabled stays high", 32'(ss_n), 1);
        wait_rx(3);

        // R6 R1 constrained random: every mode, size and divisor
        for (int it = 0; it < 24; it++) begin
            logic [1:0] w;
            int n;
            w = 2'($urandom_range(0, 3));
            cfg(w, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 9'($urandom_range(0, 3)));
            n = $urandom_range(1, wdepth(w));
            for (int k = 0; k < n; k++) begin
                words[k] = $urandom;
                push(words[k]);
            end
            wait_rx(n);
            chk("R10 rx level random", 32'(rx_level), 32'(n));
            for (int k = 0; k < n; k++) begin
                pop(got);
                chk("R6 random loopback", got, words[k] & wmask(w));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule